// File: doc/BRIEF.md
# Reset Cause Flag Register

This block is an 8-bit status register that records which kind of reset most recently hit the chip. Four single-cycle event inputs report a power-on reset, a reset from the external pin, a watchdog reset and a reset requested through the debug interface. Each event sets its own flag. Firmware reads the register early after boot to find out why the chip restarted. It then writes zero to the flags it has consumed, so that the next read shows only resets that came after that write.

The power-on event also acts as the register's own reset. It sets the power-on flag and clears the other three flags. The other reset kinds leave the register contents alone, apart from setting their own flag. The power-on flag can only be removed by firmware.

All updates are synchronous to `clk`. The register sits on a simple CPU register bus with an address, a write enable, write data and read data. The read data is combinational from the address.

Top module: `rst_cause_reg`

## Requirements
- R1: Bit positions of the register: bit 0 is the power-on flag, bit 1 the external-pin flag, bit 3 the watchdog flag and bit 4 the debug-interface flag. Bits 2, 5, 6 and 7 always read as 0.
- R2: When `bus_addr` equals `REG_ADDR`, `bus_rdata` shows the register value. Any other address reads 0x00.
- R3: An external, watchdog or debug event that is high at a rising clock edge sets its flag, which reads as 1 from the next cycle on.
- R4: A power-on event at a rising clock edge makes the register read 0x01 from the next cycle. This holds whatever the earlier flags were, and whatever other events or writes arrive in that same cycle.
- R5: External, watchdog and debug events never clear the power-on flag. The power-on flag is cleared only by a write with bit 0 at zero.
- R6: A write (`bus_we` high and `bus_addr` equal to `REG_ADDR`) clears, from the next cycle, each flag whose bit in `bus_wdata` is 0.
- R7: A write with a flag's bit at 1 leaves that flag unchanged. Software can never set a flag.
- R8: When an event and a write clearing the same flag fall in the same cycle, the flag ends up set.
- R9: Writes to the reserved bits 2, 5, 6 and 7 are ignored. Those bits still read 0 afterwards.
- R10: A write with `bus_addr` different from `REG_ADDR` changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_evt | input | 1 | Power-on reset event pulse; also acts as the register's synchronous reset |
| ext_evt | input | 1 | External-pin reset event pulse |
| wdt_evt | input | 1 | Watchdog reset event pulse |
| dbg_evt | input | 1 | Debug-interface reset event pulse |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Register bus write enable |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data |

## Verification
The hardest situations to reach are the same-cycle collisions. One is a reset event meeting a clearing write to its own flag. The other is a power-on event arriving together with other events and a write. In both, the priority decides the result, and a fault only shows when both inputs are driven in one step. The driver task takes every event and the write as arguments for a single cycle, so the stimulus builds these collisions on purpose. A reference model in the bench, written from the requirements, predicts the byte that the monitor reads back.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int NFLAG  = 4;
    localparam int DATA_W = 8;

    // flag index order inside the block: 0 power-on, 1 external, 2 watchdog, 3 debug
    localparam int IDX_POR = 0;
    localparam int IDX_EXT = 1;
    localparam int IDX_WDT = 2;
    localparam int IDX_DBG = 3;

    typedef struct packed {
        logic dbg;
        logic wdt;
        logic ext;
        logic por;
    } flags_t;

    // software-visible bit position of each flag
    function automatic int flag_bit(input int idx);
        case (idx)
            IDX_POR: flag_bit = 0;
            IDX_EXT: flag_bit = 1;
            IDX_WDT: flag_bit = 3;
            default: flag_bit = 4;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_flags(input flags_t f);
        logic [DATA_W-1:0] b;
        b = '0;
        b[flag_bit(IDX_POR)] = f.por;
        b[flag_bit(IDX_EXT)] = f.ext;
        b[flag_bit(IDX_WDT)] = f.wdt;
        b[flag_bit(IDX_DBG)] = f.dbg;
        return b;
    endfunction
endpackage

// File: rtl/rcs_bus_decode.sv
module rcs_bus_decode #(
    parameter int              ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    output logic              hit,
    output logic              wr_hit
);
    always_comb begin
        hit    = (bus_addr == REG_ADDR);
        wr_hit = hit && bus_we;
    end
endmodule

// File: rtl/rcs_flag_cell.sv
module rcs_flag_cell #(
    parameter bit IS_POR = 1'b0
) (
    input  logic clk,
    input  logic por_evt,
    input  logic set_evt,
    input  logic clr_req,
    output logic q
);
    logic q_nxt;

    generate
        if (IS_POR) begin : g_por
            // only software clears this flag; the power-on event sets it
            always_comb begin
                if (set_evt)      q_nxt = 1'b1;
                else if (clr_req) q_nxt = 1'b0;
                else              q_nxt = q;
            end
        end else begin : g_other
            // power-on clears, then own event, then software clear
            always_comb begin
                if (por_evt)      q_nxt = 1'b0;
                else if (set_evt) q_nxt = 1'b1;
                else if (clr_req) q_nxt = 1'b0;
                else              q_nxt = q;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        q <= q_nxt;
    end
endmodule

// File: rtl/rcs_readback.sv
module rcs_readback
    import rcs_pkg::*;
(
    input  flags_t            flags,
    input  logic              hit,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = hit ? pack_flags(flags) : '0;
    end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rcs_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h34
) (
    input  logic              clk,
    input  logic              por_evt,
    input  logic              ext_evt,
    input  logic              wdt_evt,
    input  logic              dbg_evt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    logic             hit;
    logic             wr_hit;
    logic [NFLAG-1:0] evt_vec;
    logic [NFLAG-1:0] clr_vec;
    logic [NFLAG-1:0] flag_q;
    flags_t           flags;

    rcs_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .hit      (hit),
        .wr_hit   (wr_hit)
    );

    always_comb begin
        evt_vec[IDX_POR] = por_evt;
        evt_vec[IDX_EXT] = ext_evt;
        evt_vec[IDX_WDT] = wdt_evt;
        evt_vec[IDX_DBG] = dbg_evt;
    end

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            localparam int BITPOS = flag_bit(i);
            assign clr_vec[i] = wr_hit && !bus_wdata[BITPOS];
            rcs_flag_cell #(.IS_POR(i == IDX_POR)) u_cell (
                .clk     (clk),
                .por_evt (por_evt),
                .set_evt (evt_vec[i]),
                .clr_req (clr_vec[i]),
                .q       (flag_q[i])
            );
        end
    endgenerate

    always_comb begin
        flags.por = flag_q[IDX_POR];
        flags.ext = flag_q[IDX_EXT];
        flags.wdt = flag_q[IDX_WDT];
        flags.dbg = flag_q[IDX_DBG];
    end

    rcs_readback u_rb (
        .flags (flags),
        .hit   (hit),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker (
    input logic       clk,
    input logic       por_evt,
    input logic       ext_evt,
    input logic       wdt_evt,
    input logic       dbg_evt,
    input logic       wr_hit,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic [3:0] flag_q
);
    logic por_seen = 1'b0;

    always_ff @(posedge clk) begin
        por_seen <= por_seen | por_evt;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_seen)
        (bus_rdata & 8'hE4) == 8'h00); // R1

    AST_POR_INIT: assert property (@(posedge clk) disable iff (!por_seen)
        por_evt |=> (flag_q == 4'b0001)); // R4

    AST_EXT_SET: assert property (@(posedge clk) disable iff (!por_seen)
        (ext_evt && !por_evt) |=> flag_q[1]); // R3

    AST_DBG_SET: assert property (@(posedge clk) disable iff (!por_seen)
        (dbg_evt && !por_evt) |=> flag_q[3]); // R3

    AST_POR_STICKY: assert property (@(posedge clk) disable iff (!por_seen)
        (!por_evt && !(wr_hit && !bus_wdata[0])) |=> $stable(flag_q[0])); // R5

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!por_seen)
        (wr_hit && !bus_wdata[1] && !ext_evt) |=> !flag_q[1]); // R6

    AST_ONES_HOLD: assert property (@(posedge clk) disable iff (!por_seen)
        (wr_hit && bus_wdata == 8'hFF && !por_evt && !ext_evt && !wdt_evt && !dbg_evt)
        |=> $stable(flag_q)); // R7

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!por_seen)
        (wdt_evt && !por_evt && wr_hit && !bus_wdata[3]) |=> flag_q[2]); // R8

    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!por_seen)
        (!wr_hit && !por_evt && !ext_evt && !wdt_evt && !dbg_evt) |=> $stable(flag_q)); // R10
endmodule

bind rst_cause_reg rcs_checker u_chk (
    .clk       (clk),
    .por_evt   (por_evt),
    .ext_evt   (ext_evt),
    .wdt_evt   (wdt_evt),
    .dbg_evt   (dbg_evt),
    .wr_hit    (wr_hit),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .flag_q    (flag_q)
);

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;
    localparam int          AW  = 6;
    localparam logic [AW-1:0] RA  = 6'h34;
    localparam logic [AW-1:0] OTH = 6'h12;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic          clk = 1'b0;
    logic          por_evt = 1'b0, ext_evt = 1'b0, wdt_evt = 1'b0, dbg_evt = 1'b0;
    logic [AW-1:0] bus_addr = RA;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;

    int    checks = 0;
    int    errors = 0;
    logic [7:0] model = 8'h00;
    item_t sb_q[$];
    bit    done = 1'b0;

    always #4 clk = ~clk;

    rst_cause_reg #(.ADDR_W(AW), .REG_ADDR(RA)) u_dut (
        .clk(clk), .por_evt(por_evt), .ext_evt(ext_evt), .wdt_evt(wdt_evt),
        .dbg_evt(dbg_evt), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // drive one cycle of stimulus, update the reference model, queue the expected read
    task automatic step(input logic p, input logic e, input logic w, input logic d,
                        input logic we, input logic [7:0] wd, input logic [AW-1:0] a,
                        input string tag);
        item_t it;
        @(negedge clk);
        por_evt = p; ext_evt = e; wdt_evt = w; dbg_evt = d;
        bus_we = we; bus_wdata = wd; bus_addr = a;
        if (p) begin
            model = 8'h01;
        end else begin
            if (we && a == RA) model = model & (wd | 8'hE4);
            if (e) model[1] = 1'b1;
            if (w) model[3] = 1'b1;
            if (d) model[4] = 1'b1;
        end
        @(posedge clk);
        it.exp = (a == RA) ? model : 8'h00;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compare the read data shortly after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s got %02h expected %02h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic direct_check(input logic [7:0] exp, input string tag);
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", tag, bus_rdata, exp);
        end
    endtask

    initial begin
        step(1, 0, 0, 0, 0, 8'h00, RA, "R4 power-on reset state");
        step(0, 0, 0, 0, 0, 8'h00, RA, "R1 idle after power-on");
        step(0, 1, 0, 0, 0, 8'h00, RA, "R3 external event");
        step(0, 0, 1, 0, 0, 8'h00, RA, "R3 watchdog event");
        step(0, 0, 0, 1, 0, 8'h00, RA, "R3 debug event");
        step(0, 0, 0, 0, 1, 8'hFF, RA, "R7 R9 write ones");
        step(0, 0, 0, 0, 1, 8'h00, OTH, "R2 read at other address");
        step(0, 0, 0, 0, 0, 8'h00, RA, "R10 write elsewhere ignored");
        @(negedge clk);
        bus_addr = OTH;
        direct_check(8'h00, "R2 other address reads zero");
        step(0, 0, 0, 0, 1, 8'hFD, RA, "R6 clear external flag");
        step(0, 1, 0, 0, 1, 8'h00, RA, "R8 event beats clear");
        step(0, 0, 0, 0, 1, 8'hFF, RA, "R5 power-on flag gone after write zero");
        step(1, 0, 0, 0, 0, 8'h00, RA, "R4 power-on again");
        step(0, 1, 1, 1, 0, 8'h00, RA, "R5 other events keep power-on flag");
        step(1, 1, 1, 1, 1, 8'hFF, RA, "R4 power-on with collisions");
        step(0, 1, 1, 1, 0, 8'h00, RA, "R3 all events together");
        step(0, 0, 0, 0, 1, 8'h1A, RA, "R5 R6 write clears only power-on");
        step(0, 0, 1, 0, 1, 8'h00, RA, "R8 watchdog beats clear");
        step(0, 0, 0, 0, 1, 8'h00, RA, "R6 clear all");
        step(0, 0, 0, 0, 1, 8'hFF, RA, "R7 ones do not set");
        step(0, 0, 0, 0, 0, 8'h00, RA, "R9 reserved stay zero");
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule